// File: doc/BRIEF.md
# Scalar Result Commit Unit

This block commits the scalar result of one instruction, one or two 32-bit dwords wide, to wherever its destination selector points. A selector may name an ordinary scalar register, one of three special registers that live at the top of the wavefront's scalar register allocation, the low or high half of the 64-bit execution mask, or some other machine register. Register-file writes leave through two dword write ports. For loads, the data for those ports comes from the memory return path, not from the computed result. Writes to other machine registers leave through a single 32-bit side port.

The execution mask is held inside the block. A write that covers only one half of the mask keeps the other half. The new mask is visible to vector write masking from the cycle after the request. A request whose dword count makes no sense for its target raises an error flag and commits nothing.

Top module: `swb_commit`

## Requirements
- R1: After reset, `exec_mask` equals the parameter `EXEC_RESET`, which is all ones by default.
- R2: A 1-dword write to selector 126 (mask low) replaces `exec_mask[31:0]` with `alu_data[31:0]` and keeps `exec_mask[63:32]`. The result is visible on the first rising edge after the request.
- R3: A 2-dword write to selector 126 replaces all 64 bits of `exec_mask` with `alu_data`.
- R4: A 1-dword write to selector 127 (mask high) replaces `exec_mask[63:32]` with `alu_data[31:0]` and keeps `exec_mask[31:0]`.
- R5: A request is in error when any of these holds: `req_ndw` is 0, `req_ndw` is greater than 2, or the selector is 127 and `req_ndw` is not 1. An error request drives `req_err` high in the same cycle. It raises no `rf_we` bit and not `misc_we`, and it leaves `exec_mask` unchanged.
- R6: For a selector below 102, `rf_we[i]` is high for each dword i < `req_ndw`. The port carries index `req_sel + i` and data `alu_data[32*i+31:32*i]`. `rf_we[1]` is never high without `rf_we[0]`.
- R7: Three special selectors are remapped relative to `rsv_top`, with dword i going to the listed index plus i:
  - selector 106 goes to `rsv_top - 2`;
  - selector 103 goes to `rsv_top - 3`;
  - selector 102 goes to `rsv_top - 4`.
- R8: When `req_load` is high, the register-file data for dword i is `ld_data[32*i+31:32*i]` instead of the ALU result.
- R9: Every other selector goes to the side port. It raises `misc_we` with `misc_sel` = `req_sel` and `misc_data` = `alu_data[31:0]`, and it raises no `rf_we` bit.
- R10: While `req_valid` is low, there are no write strobes, `req_err` stays low, and `exec_mask` holds.
- R11: A mask write raises no `rf_we` bit and not `misc_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Commit request this cycle |
| req_sel | input | 8 | Destination selector |
| req_ndw | input | 3 | Number of dwords in the result |
| req_load | input | 1 | Result comes from the load return path |
| rsv_top | input | 7 | Size of the wavefront's scalar register allocation |
| alu_data | input | 64 | Computed result, dword 0 in the low half |
| ld_data | input | 64 | Load return data, dword 0 in the low half |
| rf_we | output | 2 | Per-dword register-file write strobes |
| rf_idx | output | 2x7 | Per-dword register index |
| rf_data | output | 2x32 | Per-dword write data |
| misc_we | output | 1 | Side-port write strobe |
| misc_sel | output | 8 | Side-port selector |
| misc_data | output | 32 | Side-port data |
| exec_mask | output | 64 | Current execution mask |
| req_err | output | 1 | Malformed request, nothing committed |

## Verification
The bench targets the half-mask merges. A design that overwrote the whole mask on a 1-dword write, or wrote the wrong half, would corrupt the preserved bits, and the bench checks those bits after known prior values. Rejected widths are checked to leave the mask and every strobe untouched. A design that only flagged the error would still commit, which the bench would see.

The bench also covers the three special remaps, where an off-by-one base would land on a neighbouring register. It covers load source selection, where picking the ALU operand would show up as wrong data. It checks that the second strobe stays low on single-dword writes.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int SEL_W    = 8;
  localparam int IDX_W    = 7;
  localparam int NDW_W    = 3;
  localparam int DW       = 32;
  localparam int MAX_DW   = 2;
  localparam int NUM_SGPR = 102;

  localparam logic [SEL_W-1:0] SEL_SCR_LO  = 8'd102;
  localparam logic [SEL_W-1:0] SEL_SCR_HI  = 8'd103;
  localparam logic [SEL_W-1:0] SEL_VCC_LO  = 8'd106;
  localparam logic [SEL_W-1:0] SEL_EXEC_LO = 8'd126;
  localparam logic [SEL_W-1:0] SEL_EXEC_HI = 8'd127;

  typedef enum logic [2:0] {
    DST_SGPR,
    DST_VCC,
    DST_SCR_HI,
    DST_SCR_LO,
    DST_EXEC_LO,
    DST_EXEC_HI,
    DST_MISC
  } dst_e;
endpackage

// File: rtl/swb_decode.sv
module swb_decode
  import swb_pkg::*;
(
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  input  logic [NDW_W-1:0] ndw,
  output dst_e             dst,
  output logic             err,
  output logic             go
);
  logic bad_width;

  always_comb begin
    if (sel < SEL_W'(NUM_SGPR))  dst = DST_SGPR;
    else if (sel == SEL_VCC_LO)  dst = DST_VCC;
    else if (sel == SEL_SCR_HI)  dst = DST_SCR_HI;
    else if (sel == SEL_SCR_LO)  dst = DST_SCR_LO;
    else if (sel == SEL_EXEC_LO) dst = DST_EXEC_LO;
    else if (sel == SEL_EXEC_HI) dst = DST_EXEC_HI;
    else                         dst = DST_MISC;
  end

  always_comb begin
    bad_width = (ndw == '0) || (ndw > NDW_W'(MAX_DW));
    if (dst == DST_EXEC_HI && ndw != NDW_W'(1)) bad_width = 1'b1;
    err = valid && bad_width;
    go  = valid && !bad_width;
  end
endmodule

// File: rtl/swb_rf_map.sv
module swb_rf_map
  import swb_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  dst_e                         dst,
  input  logic [SEL_W-1:0]             sel,
  input  logic [NDW_W-1:0]             ndw,
  input  logic                         use_load,
  input  logic [IDX_W-1:0]             rsv_top,
  input  logic [MAX_DW*DW-1:0]         alu_data,
  input  logic [MAX_DW*DW-1:0]         ld_data,
  output logic [MAX_DW-1:0]            rf_we,
  output logic [MAX_DW-1:0][IDX_W-1:0] rf_idx,
  output logic [MAX_DW-1:0][DW-1:0]    rf_data
);
  logic             is_reg;
  logic [IDX_W-1:0] base_idx;

  always_comb begin
    is_reg = 1'b1;
    case (dst)
      DST_SGPR:   base_idx = sel[IDX_W-1:0];
      DST_VCC:    base_idx = rsv_top - IDX_W'(2);
      DST_SCR_HI: base_idx = rsv_top - IDX_W'(3);
      DST_SCR_LO: base_idx = rsv_top - IDX_W'(4);
      default: begin
        base_idx = '0;
        is_reg   = 1'b0;
      end
    endcase
  end

  for (genvar i = 0; i < MAX_DW; i++) begin : g_dw
    always_comb begin
      rf_we[i]   = go && is_reg && (ndw > NDW_W'(i));
      rf_idx[i]  = base_idx + IDX_W'(i);
      rf_data[i] = use_load ? ld_data[i*DW +: DW] : alu_data[i*DW +: DW];
    end
  end

  // R6
  upper_needs_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we[1] |-> rf_we[0]);
endmodule

// File: rtl/swb_exec_reg.sv
module swb_exec_reg
  import swb_pkg::*;
#(
  parameter logic [2*DW-1:0] EXEC_RESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wide,
  input  logic [2*DW-1:0] wdata,
  output logic [2*DW-1:0] mask
);
  logic [2*DW-1:0] mask_nxt;
  logic            mask_en;

  always_comb begin
    mask_en  = wr_lo || wr_hi;
    mask_nxt = mask;
    if (wr_lo && wide)  mask_nxt = wdata;
    else if (wr_lo)     mask_nxt[DW-1:0] = wdata[DW-1:0];
    else if (wr_hi)     mask_nxt[2*DW-1:DW] = wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= EXEC_RESET;
    else if (mask_en) mask <= mask_nxt;
  end

  // R2
  lo_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wide) |=> (mask[2*DW-1:DW] == $past(mask[2*DW-1:DW])) &&
                         (mask[DW-1:0] == $past(wdata[DW-1:0])));
  // R3
  lo_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && wide) |=> mask == $past(wdata));
  // R4
  hi_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (mask[DW-1:0] == $past(mask[DW-1:0])) &&
              (mask[2*DW-1:DW] == $past(wdata[DW-1:0])));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(mask));
endmodule

// File: rtl/swb_commit.sv
module swb_commit
  import swb_pkg::*;
#(
  parameter logic [2*DW-1:0] EXEC_RESET = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [SEL_W-1:0]             req_sel,
  input  logic [NDW_W-1:0]             req_ndw,
  input  logic                         req_load,
  input  logic [IDX_W-1:0]             rsv_top,
  input  logic [MAX_DW*DW-1:0]         alu_data,
  input  logic [MAX_DW*DW-1:0]         ld_data,
  output logic [MAX_DW-1:0]            rf_we,
  output logic [MAX_DW-1:0][IDX_W-1:0] rf_idx,
  output logic [MAX_DW-1:0][DW-1:0]    rf_data,
  output logic                         misc_we,
  output logic [SEL_W-1:0]             misc_sel,
  output logic [DW-1:0]                misc_data,
  output logic [2*DW-1:0]              exec_mask,
  output logic                         req_err
);
  dst_e dst;
  logic go;
  logic ex_lo_we;
  logic ex_hi_we;

  swb_decode u_dec (
    .valid (req_valid),
    .sel   (req_sel),
    .ndw   (req_ndw),
    .dst   (dst),
    .err   (req_err),
    .go    (go)
  );

  swb_rf_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .dst      (dst),
    .sel      (req_sel),
    .ndw      (req_ndw),
    .use_load (req_load),
    .rsv_top  (rsv_top),
    .alu_data (alu_data),
    .ld_data  (ld_data),
    .rf_we    (rf_we),
    .rf_idx   (rf_idx),
    .rf_data  (rf_data)
  );

  always_comb begin
    ex_lo_we  = go && (dst == DST_EXEC_LO);
    ex_hi_we  = go && (dst == DST_EXEC_HI);
    misc_we   = go && (dst == DST_MISC);
    misc_sel  = req_sel;
    misc_data = alu_data[DW-1:0];
  end

  swb_exec_reg #(.EXEC_RESET(EXEC_RESET)) u_exec (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (ex_lo_we),
    .wr_hi (ex_hi_we),
    .wide  (req_ndw == NDW_W'(2)),
    .wdata (alu_data),
    .mask  (exec_mask)
  );

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (rf_we == '0) && !misc_we);
  // R5
  err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> $stable(exec_mask));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (rf_we == '0) && !misc_we && !req_err);
  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we[0], misc_we, ex_lo_we || ex_hi_we}));
endmodule

// File: tb/tb_swb_commit.sv
module tb_swb_commit;
  import swb_pkg::*;

  logic                         clk;
  logic                         rst_n;
  logic                         req_valid;
  logic [SEL_W-1:0]             req_sel;
  logic [NDW_W-1:0]             req_ndw;
  logic                         req_load;
  logic [IDX_W-1:0]             rsv_top;
  logic [63:0]                  alu_data;
  logic [63:0]                  ld_data;
  logic [MAX_DW-1:0]            rf_we;
  logic [MAX_DW-1:0][IDX_W-1:0] rf_idx;
  logic [MAX_DW-1:0][DW-1:0]    rf_data;
  logic                         misc_we;
  logic [SEL_W-1:0]             misc_sel;
  logic [DW-1:0]                misc_data;
  logic [63:0]                  exec_mask;
  logic                         req_err;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] model;

  swb_commit dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  sel;
    logic [2:0]  ndw;
    logic        ld;
    logic [63:0] alu;
    logic [63:0] lddat;
    logic [1:0]  e_we;
    logic [6:0]  e_i0;
    logic [6:0]  e_i1;
    logic [31:0] e_d0;
    logic [31:0] e_d1;
    logic        e_misc;
    logic        e_err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    // R6 single dword
    '{8'd5,   3'd1, 1'b0, 64'h0BAD0BAD_AAAA0001, 64'h0, 2'b01, 7'd5,   7'd6,  32'hAAAA0001, 32'h0,        1'b0, 1'b0},
    // R6 pair
    '{8'd10,  3'd2, 1'b0, 64'h22222222_11111111, 64'h0, 2'b11, 7'd10,  7'd11, 32'h11111111, 32'h22222222, 1'b0, 1'b0},
    // R8 load pair
    '{8'd20,  3'd2, 1'b1, 64'h77777777_66666666, 64'h44444444_33333333, 2'b11, 7'd20, 7'd21, 32'h33333333, 32'h44444444, 1'b0, 1'b0},
    // R7 vcc pair
    '{8'd106, 3'd2, 1'b0, 64'h00000B0B_00000A0A, 64'h0, 2'b11, 7'd98,  7'd99, 32'h00000A0A, 32'h00000B0B, 1'b0, 1'b0},
    // R7 scratch high
    '{8'd103, 3'd1, 1'b0, 64'h0_00000C0C,        64'h0, 2'b01, 7'd97,  7'd98, 32'h00000C0C, 32'h0,        1'b0, 1'b0},
    // R7 scratch low
    '{8'd102, 3'd1, 1'b0, 64'h0_00000D0D,        64'h0, 2'b01, 7'd96,  7'd97, 32'h00000D0D, 32'h0,        1'b0, 1'b0},
    // R9 side port
    '{8'd110, 3'd1, 1'b0, 64'h99999999_CAFE0001, 64'h0, 2'b00, 7'd0,   7'd0,  32'h0,        32'h0,        1'b1, 1'b0},
    // R5 too wide
    '{8'd5,   3'd3, 1'b0, 64'h1,                 64'h0, 2'b00, 7'd0,   7'd0,  32'h0,        32'h0,        1'b0, 1'b1},
    // R5 zero width
    '{8'd110, 3'd0, 1'b0, 64'h1,                 64'h0, 2'b00, 7'd0,   7'd0,  32'h0,        32'h0,        1'b0, 1'b1},
    // R8 load single at top plain index
    '{8'd101, 3'd1, 1'b1, 64'h0_12121212,        64'h0_55555555, 2'b01, 7'd101, 7'd102, 32'h55555555, 32'h0,  1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] s, input logic [2:0] n,
                       input logic l, input logic [63:0] a, input logic [63:0] d);
    req_valid = v; req_sel = s; req_ndw = n; req_load = l;
    alu_data = a; ld_data = d;
  endtask

  // mask write: drive at negedge, check strobes, step one edge, check mask
  task automatic exec_op(input logic [7:0] s, input logic [2:0] n,
                         input logic [63:0] a, input logic [63:0] exp,
                         input bit exp_err, input string req);
    @(negedge clk);
    drive(1'b1, s, n, 1'b0, a, 64'h0);
    #1;
    check(req_err == exp_err, req, {63'h0, req_err}, {63'h0, exp_err});
    check(rf_we == 2'b00 && !misc_we, "R11", {61'h0, misc_we, rf_we}, 64'h0);
    @(negedge clk);
    drive(1'b0, 8'd0, 3'd1, 1'b0, 64'h0, 64'h0);
    check(exec_mask == exp, req, exec_mask, exp);
  endtask

  initial begin
    #150000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rsv_top = 7'd100;
    drive(1'b0, 8'd0, 3'd1, 1'b0, 64'h0, 64'h0);
    repeat (3) @(negedge clk);
    // R1 reset value
    check(exec_mask == 64'hFFFFFFFF_FFFFFFFF, "R1", exec_mask, 64'hFFFFFFFF_FFFFFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      bit ok;
      v = TBL[k];
      drive(1'b1, v.sel, v.ndw, v.ld, v.alu, v.lddat);
      #1;
      ok = (rf_we == v.e_we) && (misc_we == v.e_misc) && (req_err == v.e_err);
      if (v.e_we[0]) ok = ok && rf_idx[0] == v.e_i0 && rf_data[0] == v.e_d0;
      if (v.e_we[1]) ok = ok && rf_idx[1] == v.e_i1 && rf_data[1] == v.e_d1;
      if (v.e_misc)  ok = ok && misc_sel == v.sel && misc_data == v.alu[31:0];
      // table rows cover R5 R6 R7 R8 R9
      check(ok, $sformatf("table row %0d (R5 R6 R7 R8 R9)", k),
            {rf_data[0], 15'h0, misc_we, req_err, rf_idx[0], rf_we},
            {v.e_d0, 15'h0, v.e_misc, v.e_err, v.e_i0, v.e_we});
      @(negedge clk);
      drive(1'b0, 8'd0, 3'd1, 1'b0, 64'h0, 64'h0);
    end
    // R5 error rows left mask intact
    check(exec_mask == 64'hFFFFFFFF_FFFFFFFF, "R5", exec_mask, 64'hFFFFFFFF_FFFFFFFF);

    model = 64'hFFFFFFFF_FFFFFFFF;
    model[31:0] = 32'h12345678;
    exec_op(SEL_EXEC_LO, 3'd1, 64'hABABABAB_12345678, model, 1'b0, "R2");
    model = 64'h0F0F0F0F_F0F0F0F0;
    exec_op(SEL_EXEC_LO, 3'd2, model, model, 1'b0, "R3");
    model[63:32] = 32'hDEADBEEF;
    exec_op(SEL_EXEC_HI, 3'd1, 64'h11111111_DEADBEEF, model, 1'b0, "R4");
    exec_op(SEL_EXEC_HI, 3'd2, 64'h0, model, 1'b1, "R5");
    exec_op(SEL_EXEC_LO, 3'd3, 64'h0, model, 1'b1, "R5");
    model[31:0] = 32'h00000001;
    exec_op(SEL_EXEC_LO, 3'd1, 64'h0_00000001, model, 1'b0, "R2");

    // R10 idle request with a mask selector present
    @(negedge clk);
    drive(1'b0, SEL_EXEC_LO, 3'd2, 1'b0, 64'h0, 64'h0);
    #1;
    check(rf_we == 2'b00 && !misc_we && !req_err, "R10",
          {61'h0, req_err, misc_we, rf_we[0]}, 64'h0);
    @(negedge clk);
    check(exec_mask == model, "R10", exec_mask, model);

    // R1 reset again mid-run
    rst_n = 1'b0;
    #1;
    check(exec_mask == 64'hFFFFFFFF_FFFFFFFF, "R1", exec_mask, 64'hFFFFFFFF_FFFFFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule